// File: doc/BRIEF.md
# Fine Horizontal Pixel Panner

This block sits in a display refresh pipeline between the display-memory fetch and the pixel output. It unpacks 16-bit display-memory words into pixels of the selected colour depth and, at the start of every scan line, discards a small number of leading pixels from the first word. The word-granular start address, handled elsewhere, moves the image in whole words. This block supplies the remaining sub-word offset, so that horizontal scrolling can move in steps of one pixel.

A two-bit pan value is written into a small register. How many of its bits take effect depends on the colour depth. Both bits apply at 4 bpp, only the low bit applies at 8 bpp, and none apply at 16 bpp. The pan value and the depth select are captured on a frame-start pulse, so a register write made during active display takes effect at the next frame. A line-start pulse re-arms the pixel drop for the next word that arrives. Words enter, and pixels leave, on valid/ready handshakes.

Top module: `pan_fine_shifter`

## Requirements
- R1: Each input word holds four pixels at 4 bpp, two pixels at 8 bpp and one pixel at 16 bpp. The pixel shown first sits in the most significant bits: at 4 bpp pixel k is `in_word[15-4k -: 4]`, and at 8 bpp pixel k is `in_word[15-8k -: 8]`. Pixels leave in that order on `px_data`, zero-extended to 16 bits, and the words follow one another in arrival order.
- R2: With `depth_sel` = 2'b00 (4 bpp), an active pan value N from 0 to 3 drops the first N pixels of the first word accepted after each line start. Every later word of the line is delivered in full.
- R3: With `depth_sel` = 2'b01 (8 bpp), only pan bit 0 is used, so the drop is 0 or 1 pixel. Pan bit 1 has no effect.
- R4: With `depth_sel` = 2'b10 or 2'b11 (16 bpp), the pan bits have no effect and no pixel is dropped.
- R5: A write with `pan_wr_en` high stores `pan_wr_data[1:0]`. `pan_rd_data[1:0]` returns the stored value, and `pan_rd_data[3:2]` always reads zero, whatever was written to them.
- R6: `frame_start` captures the pan register value held before that clock edge, together with `depth_sel`. Changes to either one between frame starts do not affect the output until the next `frame_start`.
- R7: While `line_start` or `frame_start` is high, `in_ready` is low. In the following cycle `px_valid` is low, and any pixels of the held word that were not yet delivered are discarded. The next word accepted is treated as the first word of a line.
- R8: When a word is accepted, its first delivered pixel appears on `px_valid`/`px_data` in the next cycle. A pixel that is not taken is held stable. When `px_ready` stays high, the next word is accepted in the same cycle as the last pixel of the held word, so the pixel stream has no gaps.
- R9: After reset, `px_valid` is low, `in_ready` is high and `pan_rd_data` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse: captures pan and depth, and restarts the line |
| line_start | input | 1 | One-cycle pulse: restarts the pixel position for a new line |
| depth_sel | input | 2 | Colour depth: 00 = 4 bpp, 01 = 8 bpp, 1x = 16 bpp |
| pan_wr_en | input | 1 | Pan register write strobe |
| pan_wr_data | input | 4 | Pan register write data (bits 3:2 are reserved) |
| pan_rd_data | output | 4 | Pan register read-back (bits 3:2 read zero) |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_word | input | 16 | Display-memory word |
| px_valid | output | 1 | Output pixel valid |
| px_ready | input | 1 | Consumer takes the pixel this cycle |
| px_data | output | 16 | Pixel value, zero-extended |

## Verification
An accepted word shows its first delivered pixel one cycle later. A restart pulse blanks `px_valid` in the next cycle, and a register write becomes visible on the read-back port one cycle after the strobe. The bench drives every input on the falling edge and samples every output 2 ns later, so each comparison sees the values that will be registered at the coming rising edge. The scoreboard matches pixels by order rather than by cycle, so backpressure patterns cannot shift the expected data. The dedicated latency, hold, restart and gap-free checks count cycles explicitly from the accepting edge.

// File: rtl/pan_pkg.sv
package pan_pkg;

    localparam int WORD_W  = 16;
    localparam int PAN_W   = 2;
    localparam int REG_W   = 4;
    localparam int IDX_W   = 2;
    localparam int DSEL_W  = 2;

    typedef enum logic [1:0] {
        DEPTH_4  = 2'd0,
        DEPTH_8  = 2'd1,
        DEPTH_16 = 2'd2
    } depth_e;

    typedef struct packed {
        depth_e             depth;
        logic [PAN_W-1:0]   pan;
    } cfg_t;

    function automatic depth_e decode_depth(logic [DSEL_W-1:0] sel);
        case (sel)
            2'b00:   return DEPTH_4;
            2'b01:   return DEPTH_8;
            default: return DEPTH_16;
        endcase
    endfunction

    function automatic int unsigned bits_per_pixel(depth_e d);
        case (d)
            DEPTH_4: return 4;
            DEPTH_8: return 8;
            default: return WORD_W;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] last_idx(depth_e d);
        return IDX_W'(WORD_W / bits_per_pixel(d) - 1);
    endfunction

    // Only pan bits that index a pixel inside one word are kept
    function automatic logic [PAN_W-1:0] eff_pan(depth_e d, logic [PAN_W-1:0] p);
        case (d)
            DEPTH_4: return p;
            DEPTH_8: return {1'b0, p[0]};
            default: return '0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] pick_pixel(depth_e d,
                                                     logic [WORD_W-1:0] w,
                                                     logic [IDX_W-1:0] idx);
        int unsigned        bpp;
        int unsigned        sh;
        logic [WORD_W-1:0]  mask;
        bpp  = bits_per_pixel(d);
        sh   = (int'(last_idx(d)) - int'(idx)) * bpp;
        mask = {WORD_W{1'b1}} >> (WORD_W - bpp);
        return (w >> sh) & mask;
    endfunction

endpackage

// File: rtl/pan_cfg_reg.sv
module pan_cfg_reg
    import pan_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_start,
    input  logic [DSEL_W-1:0]   depth_sel,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    output cfg_t                cfg
);
    localparam int RSV_W = REG_W - PAN_W;

    logic [PAN_W-1:0] pan_q;
    cfg_t             cfg_q;
    depth_e           dsel;

    assign dsel = decode_depth(depth_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            pan_q <= '0;
            cfg_q <= '{depth: DEPTH_4, pan: '0};
        end else begin
            if (wr_en)
                pan_q <= wr_data[PAN_W-1:0];
            if (frame_start)
                cfg_q <= '{depth: dsel, pan: eff_pan(dsel, pan_q)};
        end
    end

    assign rd_data = {{RSV_W{1'b0}}, pan_q};
    assign cfg     = cfg_q;
endmodule

// File: rtl/pan_word_unpacker.sv
module pan_word_unpacker
    import pan_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  cfg_t                cfg,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WORD_W-1:0]   in_word,
    output logic                hold_valid,
    input  logic                take,
    output logic [WORD_W-1:0]   word,
    output logic [IDX_W-1:0]    idx
);
    logic               have_q;
    logic               first_q;
    logic [WORD_W-1:0]  word_q;
    logic [IDX_W-1:0]   idx_q;
    logic               at_last;
    logic               accept;

    assign at_last    = (idx_q == last_idx(cfg.depth));
    assign hold_valid = have_q && !restart;
    assign in_ready   = !restart && (!have_q || (take && at_last));
    assign accept     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_q  <= 1'b0;
            first_q <= 1'b1;
            word_q  <= '0;
            idx_q   <= '0;
        end else if (restart) begin
            have_q  <= 1'b0;
            first_q <= 1'b1;
            idx_q   <= '0;
        end else if (accept) begin
            word_q  <= in_word;
            idx_q   <= first_q ? cfg.pan : '0;
            have_q  <= 1'b1;
            first_q <= 1'b0;
        end else if (take) begin
            if (at_last)
                have_q <= 1'b0;
            else
                idx_q  <= idx_q + 1'b1;
        end
    end

    assign word = word_q;
    assign idx  = idx_q;
endmodule

// File: rtl/pan_pixel_select.sv
module pan_pixel_select
    import pan_pkg::*;
(
    input  depth_e              depth,
    input  logic [WORD_W-1:0]   word,
    input  logic [IDX_W-1:0]    idx,
    output logic [WORD_W-1:0]   pixel
);
    always_comb pixel = pick_pixel(depth, word, idx);
endmodule

// File: rtl/pan_fine_shifter.sv
module pan_fine_shifter
    import pan_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_start,
    input  logic                line_start,
    input  logic [DSEL_W-1:0]   depth_sel,
    input  logic                pan_wr_en,
    input  logic [REG_W-1:0]    pan_wr_data,
    output logic [REG_W-1:0]    pan_rd_data,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WORD_W-1:0]   in_word,
    output logic                px_valid,
    input  logic                px_ready,
    output logic [WORD_W-1:0]   px_data
);
    cfg_t               cfg;
    logic               restart;
    logic               take;
    logic [WORD_W-1:0]  cur_word;
    logic [IDX_W-1:0]   cur_idx;

    assign restart = frame_start || line_start;
    assign take    = px_valid && px_ready;

    pan_cfg_reg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .depth_sel   (depth_sel),
        .wr_en       (pan_wr_en),
        .wr_data     (pan_wr_data),
        .rd_data     (pan_rd_data),
        .cfg         (cfg)
    );

    pan_word_unpacker u_unpack (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .cfg        (cfg),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_word    (in_word),
        .hold_valid (px_valid),
        .take       (take),
        .word       (cur_word),
        .idx        (cur_idx)
    );

    pan_pixel_select u_sel (
        .depth (cfg.depth),
        .word  (cur_word),
        .idx   (cur_idx),
        .pixel (px_data)
    );
endmodule

// File: rtl/pan_fine_shifter_chk.sv
module pan_fine_shifter_chk
    import pan_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                frame_start,
    input logic                line_start,
    input logic [REG_W-1:0]    pan_rd_data,
    input logic                in_valid,
    input logic                in_ready,
    input logic                px_valid,
    input logic                px_ready,
    input logic [WORD_W-1:0]   px_data
);
    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        pan_rd_data[REG_W-1:PAN_W] == '0);                                  // R5

    AST_RESTART_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        (line_start || frame_start) |-> !in_ready);                         // R7

    AST_RESTART_BLANKS_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        (line_start || frame_start) |=> !px_valid);                         // R7

    AST_ACCEPT_SHOWS_PIXEL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (px_valid || line_start || frame_start)); // R8

    AST_STALL_HOLDS_PIXEL: assert property (@(posedge clk) disable iff (rst)
        (px_valid && !px_ready && !line_start && !frame_start)
        |=> ($stable(px_data) && (px_valid || line_start || frame_start))); // R8
endmodule

bind pan_fine_shifter pan_fine_shifter_chk chk_i (.*);

// File: tb/pan_fine_shifter_tb_top.sv
module pan_fine_shifter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic        line_start = 1'b0;
    logic [1:0]  depth_sel = 2'b00;
    logic        pan_wr_en = 1'b0;
    logic [3:0]  pan_wr_data = 4'h0;
    logic [3:0]  pan_rd_data;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_word = 16'h0;
    logic        px_valid;
    logic        px_ready = 1'b0;
    logic [15:0] px_data;

    always #2.5 clk = ~clk;

    pan_fine_shifter dut_i (.*);

    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] exp_q[$];
    string       cur_tag = "R1";
    int          rdy_mode = 0;   // 0 hold low, 1 hold high, 2 pattern
    bit          mon_en = 1'b0;
    int          cyc = 0;
    int          first_hs = -1;
    int          last_hs = -1;
    int          word_ctr = 0;
    logic [7:0]  lfsr = 8'h5B;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: compares each accepted pixel with the scoreboard queue
    always begin
        @(negedge clk);
        case (rdy_mode)
            0:       px_ready = 1'b0;
            1:       px_ready = 1'b1;
            default: begin
                lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                px_ready = lfsr[0] | lfsr[2];
            end
        endcase
        #2;
        if (mon_en && px_valid && px_ready) begin
            if (first_hs < 0) first_hs = cyc;
            last_hs = cyc;
            if (exp_q.size() == 0)
                chk(1'b0, {cur_tag, " unexpected pixel"}, px_data, 16'hxxxx);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(px_data == e, cur_tag, px_data, e);
            end
        end
    end

    function automatic int ref_pan(input logic [1:0] dsel, input logic [1:0] p);
        if (dsel == 2'b00) return int'(p);
        if (dsel == 2'b01) return int'(p[0]);
        return 0;
    endfunction

    task automatic push_expected(input logic [15:0] w, input logic [1:0] dsel, input int start);
        int bpp = (dsel == 2'b00) ? 4 : (dsel == 2'b01) ? 8 : 16;
        int ppw = 16 / bpp;
        for (int k = start; k < ppw; k++)
            exp_q.push_back((w >> (16 - bpp * (k + 1))) & (16'hFFFF >> (16 - bpp)));
    endtask

    task automatic send_word(input logic [15:0] w, input logic [1:0] dsel, input int start);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        #2;
        while (!in_ready) begin
            @(negedge clk);
            #2;
        end
        push_expected(w, dsel, start);
        @(posedge clk);
    endtask

    task automatic pulse_line();
        @(negedge clk); in_valid = 1'b0; line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
    endtask

    task automatic pulse_frame();
        @(negedge clk); in_valid = 1'b0; frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic write_pan(input logic [3:0] v);
        @(negedge clk); pan_wr_en = 1'b1; pan_wr_data = v;
        @(negedge clk); pan_wr_en = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // exp_dsel/exp_pan: configuration the bench believes is active
    task automatic run_line(input logic [1:0] exp_dsel, input logic [1:0] exp_pan,
                            input int nwords, input string tag);
        cur_tag = tag;
        pulse_line();
        for (int i = 0; i < nwords; i++) begin
            logic [15:0] w;
            word_ctr++;
            w = 16'hA5C3 ^ (16'(word_ctr) * 16'h1357);
            send_word(w, exp_dsel, (i == 0) ? ref_pan(exp_dsel, exp_pan) : 0);
        end
        @(negedge clk); in_valid = 1'b0;
        drain();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R9 reset state
        chk(px_valid == 1'b0, "R9 px_valid", 16'(px_valid), 16'h0);
        chk(in_ready == 1'b1, "R9 in_ready", 16'(in_ready), 16'h1);
        chk(pan_rd_data == 4'h0, "R9 pan_rd_data", 16'(pan_rd_data), 16'h0);

        // R5 reserved bits read zero
        write_pan(4'hF);
        #2;
        chk(pan_rd_data == 4'h3, "R5 read-back", 16'(pan_rd_data), 16'h3);
        write_pan(4'hD);
        #2;
        chk(pan_rd_data == 4'h1, "R5 read-back", 16'(pan_rd_data), 16'h1);

        // R8 latency and hold, R7 discard of a held word
        depth_sel = 2'b00;
        write_pan(4'h0);
        pulse_frame();
        @(negedge clk); line_start = 1'b1;
        #2;
        chk(in_ready == 1'b0, "R7 in_ready during line_start", 16'(in_ready), 16'h0);
        @(negedge clk); line_start = 1'b0;
        @(negedge clk); in_valid = 1'b1; in_word = 16'h9ABC;
        #2;
        chk(in_ready == 1'b1, "R8 in_ready idle", 16'(in_ready), 16'h1);
        @(negedge clk); in_valid = 1'b0;
        #2;
        chk(px_valid == 1'b1, "R8 px_valid one cycle after accept", 16'(px_valid), 16'h1);
        chk(px_data == 16'h0009, "R8 R1 first pixel", px_data, 16'h0009);
        @(negedge clk);
        #2;
        chk(px_valid == 1'b1 && px_data == 16'h0009, "R8 stalled pixel held", px_data, 16'h0009);
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
        #2;
        chk(px_valid == 1'b0, "R7 held word discarded", 16'(px_valid), 16'h0);

        // R8 gap-free streaming
        mon_en = 1'b1;
        rdy_mode = 1;
        first_hs = -1;
        run_line(2'b00, 2'b00, 3, "R8 R1");
        chk(last_hs - first_hs == 11, "R8 twelve pixels back to back",
            16'(last_hs - first_hs), 16'd11);

        // R2 R3 R4 every depth and pan value, with and without backpressure
        for (int d = 0; d < 4; d++) begin
            for (int p = 0; p < 4; p++) begin
                string tag;
                tag = (d == 0) ? "R2 R1" : (d == 1) ? "R3 R1" : "R4 R1";
                depth_sel = 2'(d);
                write_pan(4'(p) | 4'hC);
                pulse_frame();
                rdy_mode = (p[0]) ? 2 : 1;
                run_line(2'(d), 2'(p), 3, tag);
                run_line(2'(d), 2'(p), 2, tag);
            end
        end

        // R6 mid-frame changes wait for the next frame start
        depth_sel = 2'b00;
        write_pan(4'h1);
        pulse_frame();
        rdy_mode = 2;
        run_line(2'b00, 2'b01, 2, "R6 before change");
        write_pan(4'h3);
        depth_sel = 2'b01;
        run_line(2'b00, 2'b01, 2, "R6 mid-frame ignored");
        pulse_frame();
        run_line(2'b01, 2'b11, 2, "R6 next frame");
        // frame_start together with a write captures the older value
        depth_sel = 2'b00;
        @(negedge clk); pan_wr_en = 1'b1; pan_wr_data = 4'h2; frame_start = 1'b1;
        @(negedge clk); pan_wr_en = 1'b0; frame_start = 1'b0;
        run_line(2'b00, 2'b11, 2, "R6 same-edge write");

        mon_en = 1'b0;
        chk(exp_q.size() == 0, "R1 queue empty at end", 16'(exp_q.size()), 16'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule